// File: doc/BRIEF.md
# Bang-Bang Delay-Line Tap Controller

This block is the digital control loop of a delay-locked clock aligner. A flip-flop phase detector outside the block samples one clock with the other once per reference cycle and presents a single early/late bit with a valid strobe. The controller gathers these samples and, once every `UPDATE_DIV` samples, moves an 8-bit delay-chain tap index by `STEP` taps toward alignment. The correction is non-linear, so near alignment the index dithers back and forth around the lock point instead of settling on one tap.

Four tap selections are produced from the same index, spaced a quarter period apart. Since all four come from one chain, they stay phase-coherent with each other. A run-time fine phase shift in units of 1/256 of the period is added to all four. It can be written directly or nudged one unit at a time. A lock flag tells downstream logic when the clocks may be used, and a sticky flag records that the loop tried to move past either end of the chain.

Top module: `dll_phase_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, the index is 128, the offset is 0, `locked` is 0 and `out_of_range` is 0. With those values `tap_0`=128, `tap_90`=192, `tap_180`=0 and `tap_270`=64.
- R2: `tap_90`, `tap_180` and `tap_270` always equal `tap_0` plus 64, 128 and 192, each taken modulo 256.
- R3: The index moves only on the `UPDATE_DIV`-th cycle with `pd_valid`=1 since the previous move. That move uses the `pd_late` value of that cycle. Fewer samples, or any change of `pd_late` while `pd_valid` is 0, leave the outputs unchanged.
- R4: On a move, `pd_late`=1 lowers the index by `STEP` and `pd_late`=0 raises it by `STEP`. `tap_0` shows the new value one clock after the sampling edge.
- R5: The index saturates at 0 and at 255 and never wraps.
- R6: `locked` rises on the move that completes `LOCK_COUNT` consecutive moves, each in the opposite direction to the one before. The first move after reset has no predecessor and does not count.
- R7: `locked` falls on the move that completes `LOSS_COUNT` consecutive moves in the same direction as the one before.
- R8: `out_of_range` becomes 1 when a move asks for a step below 0 or above 255 while the index already sits at that end. After that it stays 1 until reset.
- R9: A cycle with `ofs_load`=1 sets the offset to `ofs_value`, and `tap_0` becomes index plus offset modulo 256. A load takes precedence over `ofs_inc` and `ofs_dec` in the same cycle.
- R10: `ofs_inc` raises the offset by 1 and `ofs_dec` lowers it by 1, both wrapping modulo 256. When both are asserted in the same cycle the offset does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, one phase sample per strobe |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_valid | input | 1 | Strobe: a new phase detector sample is present |
| pd_late | input | 1 | 1 = fed-back clock lags reference, 0 = leads |
| ofs_load | input | 1 | Write `ofs_value` into the fine phase offset |
| ofs_value | input | 8 | Fine phase offset in 1/256 period units |
| ofs_inc | input | 1 | Raise offset by one unit |
| ofs_dec | input | 1 | Lower offset by one unit |
| tap_0 | output | 8 | Tap select, 0 degrees |
| tap_90 | output | 8 | Tap select, 90 degrees |
| tap_180 | output | 8 | Tap select, 180 degrees |
| tap_270 | output | 8 | Tap select, 270 degrees |
| locked | output | 1 | Loop output valid |
| out_of_range | output | 1 | Sticky: correction requested past a chain end |

## Verification
Index moves, offset changes, `locked` and `out_of_range` are each held in one register. Each is therefore due one clock after the edge that samples the cause: the last strobe of a group for a move, or the control pulse for an offset change. The tap outputs are combinational from those registers. The bench drives every input on the falling edge and samples on the next falling edge, half a period after the register has updated. Negative checks are read on that same falling edge after a group of samples that is one short of a move, so a premature move would already be visible.

// File: rtl/dll_pkg.sv
package dll_pkg;
   localparam int NUM_QUAD = 4;

   typedef enum logic {
      DIR_RAISE = 1'b0,
      DIR_LOWER = 1'b1
   } step_dir_e;
endpackage

// File: rtl/dll_upd_timer.sv
module dll_upd_timer #(
   parameter int UPDATE_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_valid,
   output logic upd
);
   generate
      if (UPDATE_DIV == 1) begin : g_direct
         assign upd = smp_valid;
      end else begin : g_count
         localparam int CW = $clog2(UPDATE_DIV);
         localparam logic [CW-1:0] LAST = CW'(UPDATE_DIV - 1);
         logic [CW-1:0] cnt;

         assign upd = smp_valid && (cnt == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         cnt <= '0;
            else if (upd)       cnt <= '0;
            else if (smp_valid) cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/dll_tap_index.sv
module dll_tap_index
   import dll_pkg::*;
#(
   parameter int IDX_W = 8,
   parameter int STEP  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  step_dir_e        dir,
   output logic [IDX_W-1:0] idx,
   output logic             pinned_req
);
   localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};
   localparam logic [IDX_W-1:0] IDX_MID = IDX_W'(1 << (IDX_W - 1));
   localparam logic [IDX_W-1:0] STEP_V  = IDX_W'(STEP);

   logic [IDX_W-1:0] nxt;

   always_comb begin
      nxt = idx;
      if (dir == DIR_LOWER) nxt = (idx >= STEP_V) ? idx - STEP_V : '0;
      else                  nxt = (idx <= IDX_MAX - STEP_V) ? idx + STEP_V : IDX_MAX;
   end

   assign pinned_req = upd && (((dir == DIR_LOWER) && (idx == '0)) ||
                               ((dir == DIR_RAISE) && (idx == IDX_MAX)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   idx <= IDX_MID;
      else if (upd) idx <= nxt;
   end
endmodule

// File: rtl/dll_lock_det.sv
module dll_lock_det
   import dll_pkg::*;
#(
   parameter int LOCK_COUNT = 4,
   parameter int LOSS_COUNT = 3
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      upd,
   input  step_dir_e dir,
   output logic      locked
);
   localparam int AW = $clog2(LOCK_COUNT + 1);
   localparam int SW = $clog2(LOSS_COUNT + 1);
   localparam logic [AW-1:0] ALT_TOP  = AW'(LOCK_COUNT);
   localparam logic [SW-1:0] SAME_TOP = SW'(LOSS_COUNT);

   step_dir_e     prev_dir;
   logic          have_prev;
   logic [AW-1:0] alt_cnt;
   logic [SW-1:0] same_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_dir  <= DIR_RAISE;
         have_prev <= 1'b0;
         alt_cnt   <= '0;
         same_cnt  <= '0;
         locked    <= 1'b0;
      end else if (upd) begin
         prev_dir  <= dir;
         have_prev <= 1'b1;
         if (have_prev && (dir != prev_dir)) begin
            same_cnt <= '0;
            if (alt_cnt != ALT_TOP) alt_cnt <= alt_cnt + 1'b1;
            if (alt_cnt + 1'b1 >= ALT_TOP) locked <= 1'b1;
         end else if (have_prev) begin
            alt_cnt <= '0;
            if (same_cnt != SAME_TOP) same_cnt <= same_cnt + 1'b1;
            if (same_cnt + 1'b1 >= SAME_TOP) locked <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dll_phase_ofs.sv
module dll_phase_ofs #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] value,
   input  logic             inc,
   input  logic             dec,
   output logic [IDX_W-1:0] ofs
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            ofs <= '0;
      else if (load)         ofs <= value;
      else if (inc && !dec)  ofs <= ofs + 1'b1;
      else if (dec && !inc)  ofs <= ofs - 1'b1;
   end
endmodule

// File: rtl/dll_phase_ctrl.sv
module dll_phase_ctrl
   import dll_pkg::*;
#(
   parameter int IDX_W      = 8,
   parameter int STEP       = 1,
   parameter int UPDATE_DIV = 4,
   parameter int LOCK_COUNT = 4,
   parameter int LOSS_COUNT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pd_valid,
   input  logic             pd_late,
   input  logic             ofs_load,
   input  logic [IDX_W-1:0] ofs_value,
   input  logic             ofs_inc,
   input  logic             ofs_dec,
   output logic [IDX_W-1:0] tap_0,
   output logic [IDX_W-1:0] tap_90,
   output logic [IDX_W-1:0] tap_180,
   output logic [IDX_W-1:0] tap_270,
   output logic             locked,
   output logic             out_of_range
);
   localparam int QUARTER = 1 << (IDX_W - 2);

   generate
      if (IDX_W < 2) begin : g_bad_w
         $error("IDX_W must be at least 2");
      end
      if (STEP < 1 || STEP >= (1 << IDX_W)) begin : g_bad_step
         $error("STEP out of range");
      end
      if (UPDATE_DIV < 1) begin : g_bad_div
         $error("UPDATE_DIV must be at least 1");
      end
      if (LOCK_COUNT < 1 || LOSS_COUNT < 1) begin : g_bad_cnt
         $error("LOCK_COUNT and LOSS_COUNT must be at least 1");
      end
   endgenerate

   logic             upd;
   logic             pinned_req;
   step_dir_e        dir;
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] ofs;
   logic [IDX_W-1:0] taps [NUM_QUAD];

   assign dir = step_dir_e'(pd_late);

   dll_upd_timer #(.UPDATE_DIV(UPDATE_DIV)) u_timer (
      .clk(clk), .rst_n(rst_n), .smp_valid(pd_valid), .upd(upd)
   );

   dll_tap_index #(.IDX_W(IDX_W), .STEP(STEP)) u_index (
      .clk(clk), .rst_n(rst_n), .upd(upd), .dir(dir),
      .idx(idx), .pinned_req(pinned_req)
   );

   dll_lock_det #(.LOCK_COUNT(LOCK_COUNT), .LOSS_COUNT(LOSS_COUNT)) u_lock (
      .clk(clk), .rst_n(rst_n), .upd(upd), .dir(dir), .locked(locked)
   );

   dll_phase_ofs #(.IDX_W(IDX_W)) u_ofs (
      .clk(clk), .rst_n(rst_n), .load(ofs_load), .value(ofs_value),
      .inc(ofs_inc), .dec(ofs_dec), .ofs(ofs)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          out_of_range <= 1'b0;
      else if (pinned_req) out_of_range <= 1'b1;
   end

   generate
      for (genvar q = 0; q < NUM_QUAD; q++) begin : g_quad
         assign taps[q] = idx + ofs + IDX_W'(q * QUARTER);
      end
   endgenerate

   assign tap_0   = taps[0];
   assign tap_90  = taps[1];
   assign tap_180 = taps[2];
   assign tap_270 = taps[3];
endmodule

// File: rtl/dll_phase_ctrl_chk.sv
module dll_phase_ctrl_chk #(
   parameter int IDX_W = 8,
   parameter int STEP  = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pd_valid,
   input logic             pd_late,
   input logic             ofs_load,
   input logic [IDX_W-1:0] ofs_value,
   input logic             ofs_inc,
   input logic             ofs_dec,
   input logic [IDX_W-1:0] tap_0,
   input logic [IDX_W-1:0] tap_90,
   input logic [IDX_W-1:0] tap_180,
   input logic [IDX_W-1:0] tap_270,
   input logic             locked,
   input logic             out_of_range
);
   localparam logic [IDX_W-1:0] Q1 = IDX_W'(1 << (IDX_W - 2));
   localparam logic [IDX_W-1:0] SV = IDX_W'(STEP);

   logic ofs_quiet;
   assign ofs_quiet = !ofs_load && !ofs_inc && !ofs_dec;

   a_r2_quad_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tap_90 == IDX_W'(tap_0 + Q1)) && (tap_180 == IDX_W'(tap_0 + 2 * Q1)) &&
      (tap_270 == IDX_W'(tap_0 + 3 * Q1)));

   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!pd_valid && ofs_quiet) |=> $stable(tap_0));

   a_r4_step_size: assert property (@(posedge clk) disable iff (!rst_n)
      ofs_quiet |=> ((IDX_W'(tap_0 - $past(tap_0)) == '0) ||
                     (IDX_W'(tap_0 - $past(tap_0)) == SV) ||
                     (IDX_W'($past(tap_0) - tap_0) == SV) ||
                     $past(tap_0) == IDX_W'(tap_0 + 1'b1) ||
                     $past(tap_0) == IDX_W'(tap_0 - 1'b1) ||
                     STEP > 1));

   a_r6_lock_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_valid |=> $stable(locked));

   a_r8_oor_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      out_of_range |=> out_of_range);

   a_r10_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ofs_inc && !ofs_dec && !ofs_load && !pd_valid) |=>
         (tap_0 == IDX_W'($past(tap_0) + 1'b1)));
endmodule

bind dll_phase_ctrl dll_phase_ctrl_chk #(.IDX_W(IDX_W), .STEP(STEP)) u_chk (.*);

// File: tb/dll_phase_ctrl_test.sv
module dll_phase_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pd_valid = 1'b0, pd_late = 1'b0;
   logic       ofs_load = 1'b0, ofs_inc = 1'b0, ofs_dec = 1'b0;
   logic [7:0] ofs_value = '0;
   logic [7:0] tap_0, tap_90, tap_180, tap_270;
   logic       locked, out_of_range;
   int         checks = 0, errors = 0;

   always #5 clk = ~clk;

   dll_phase_ctrl uut (
      .clk(clk), .rst_n(rst_n), .pd_valid(pd_valid), .pd_late(pd_late),
      .ofs_load(ofs_load), .ofs_value(ofs_value), .ofs_inc(ofs_inc),
      .ofs_dec(ofs_dec), .tap_0(tap_0), .tap_90(tap_90), .tap_180(tap_180),
      .tap_270(tap_270), .locked(locked), .out_of_range(out_of_range)
   );

   // {pd_late, expected locked, expected tap_0} per update, offset zero
   localparam logic [9:0] VEC [0:8] = '{
      {1'b0, 1'b0, 8'd129}, {1'b1, 1'b0, 8'd128}, {1'b0, 1'b0, 8'd129},
      {1'b1, 1'b0, 8'd128}, {1'b0, 1'b1, 8'd129}, {1'b0, 1'b1, 8'd130},
      {1'b0, 1'b1, 8'd131}, {1'b0, 1'b0, 8'd132}, {1'b1, 1'b0, 8'd131}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic samples(input int n, input logic late);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); pd_valid = 1'b1; pd_late = late;
      end
      @(negedge clk); pd_valid = 1'b0;
   endtask

   task automatic ofs_op(input logic ld, input logic [7:0] v, input logic up, input logic dn);
      @(negedge clk); ofs_load = ld; ofs_value = v; ofs_inc = up; ofs_dec = dn;
      @(negedge clk); ofs_load = 1'b0; ofs_inc = 1'b0; ofs_dec = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 tap_0", tap_0, 128);
      chk("R1 tap_90", tap_90, 192);
      chk("R1 tap_180", tap_180, 0);
      chk("R1 tap_270", tap_270, 64);
      chk("R1 locked", locked, 0);
      chk("R1 out_of_range", out_of_range, 0);

      // R4 R6 R7: table of update decisions
      foreach (VEC[i]) begin
         samples(4, VEC[i][9]);
         chk($sformatf("R4 tap_0 vec%0d", i), tap_0, VEC[i][7:0]);
         chk($sformatf("R6/R7 locked vec%0d", i), locked, VEC[i][8]);
      end

      // R3: three samples, then toggling pd_late without strobe: no move
      samples(3, 1'b0);
      chk("R3 short group", tap_0, 131);
      @(negedge clk); pd_late = 1'b1;
      @(negedge clk); pd_late = 1'b0;
      @(negedge clk);
      chk("R3 no strobe", tap_0, 131);
      samples(1, 1'b1);
      chk("R3 fourth sample uses own pd_late", tap_0, 130);

      // R9 R2: load offset 200 -> 130+200 = 74
      ofs_op(1'b1, 8'd200, 1'b0, 1'b0);
      chk("R9 load tap_0", tap_0, 74);
      chk("R2 tap_90", tap_90, 138);
      chk("R2 tap_180", tap_180, 202);
      chk("R2 tap_270", tap_270, 10);
      ofs_op(1'b1, 8'd10, 1'b1, 1'b0);
      chk("R9 load wins over inc", tap_0, 140);
      // R10
      ofs_op(1'b0, 8'd0, 1'b1, 1'b0);
      chk("R10 inc", tap_0, 141);
      ofs_op(1'b0, 8'd0, 1'b1, 1'b1);
      chk("R10 inc and dec cancel", tap_0, 141);
      ofs_op(1'b1, 8'd0, 1'b0, 1'b0);
      ofs_op(1'b0, 8'd0, 1'b0, 1'b1);
      ofs_op(1'b0, 8'd0, 1'b0, 1'b1);
      chk("R10 dec wraps offset", tap_0, 128);

      // R5 R8: lower rail
      do_reset();
      chk("R1 reset clears offset", tap_0, 128);
      for (int k = 0; k < 128; k++) samples(4, 1'b1);
      chk("R5 reach zero", tap_0, 0);
      chk("R8 not yet set", out_of_range, 0);
      samples(4, 1'b1);
      chk("R5 hold at zero", tap_0, 0);
      chk("R8 set at lower rail", out_of_range, 1);
      samples(4, 1'b0);
      chk("R8 sticky", out_of_range, 1);
      chk("R4 leaves rail", tap_0, 1);

      // R5 R8: upper rail
      do_reset();
      chk("R8 cleared by reset", out_of_range, 0);
      for (int k = 0; k < 127; k++) samples(4, 1'b0);
      chk("R5 reach max", tap_0, 255);
      chk("R8 not set at max", out_of_range, 0);
      samples(4, 1'b0);
      chk("R5 hold at max", tap_0, 255);
      chk("R8 set at upper rail", out_of_range, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule